// File: doc/BRIEF.md
# Pipelined Burst Static RAM with Lane Write Masking

This block is a cycle-accurate, synthesizable model of a synchronous static RAM that streams short bursts. On every rising clock edge on which the clock hold input is low it samples three chip-select pins, a burst-step control, a read/write select and one write strobe per byte lane. From these it decides whether to load a new external address, step an internal burst counter, stay deselected or drop a write. The default array holds 256 words of 32 bits split into four 8-bit lanes.

Every access is pipelined. The address and command are taken on one edge, and the array is touched on the second enabled edge after that. On that edge read data is registered onto the output, or write data is taken from the write bus. Reads and writes can therefore follow each other on consecutive cycles with no gap. The output is a data bus with a separate drive-enable flag. An asynchronous output-enable pin gates the flag, which gives a dummy read when it is high.

Top module: `burst_sram`

## Requirements
- R1: While reset is asserted and on the first cycles after it is released, `rdata_en` is 0 and `rdata` is all zeros.
- R2: On an edge where `clk_en_n` is 1, nothing changes: the burst address, direction, pipeline contents, memory and output register all hold. On the following enabled edges the sequence continues as though the held edge had never happened.
- R3: The chip is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. An enabled edge with `burst_step`=0 and any other combination is a deselect, which performs no access and ends any active burst.
- R4: An enabled edge with `burst_step`=0 and the chip selected loads `addr` and begins a burst. `wr_req_n`=1 makes it a read burst and `wr_req_n`=0 makes it a write burst.
- R5: An enabled edge with `burst_step`=1 during an active burst accesses the next address and keeps the burst direction. The next address adds 1 modulo 4 to bits [1:0] and keeps the upper bits fixed.
- R6: `burst_step`=1 while deselected is a continue-deselect. It performs no access and writes nothing, whatever the write and lane inputs are.
- R7: A write access updates lane i (bits [8i+7:8i]) only when `lane_wr_n[i]` was 0 on the edge that issued the access. Any subset of lanes may be written.
- R8: A write access with all four `lane_wr_n` bits at 1 is an abort. The burst address still loads or steps as usual, but no memory bit changes.
- R9: Read data for an access issued on enabled edge k appears after enabled edge k+2, with `rdata_en`=1. Write data on `wdata` is taken on enabled edge k+2.
- R10: `rdata_en` is 1 only when the output register holds read data and `out_en_n` is 0. Whenever `rdata_en` is 0, `rdata` is zero. `out_en_n` acts combinationally, and a read taken with it high is a dummy read that still advances the address.
- R11: Read and write accesses may alternate on consecutive enabled edges with no idle cycle, and each read returns the data most recently written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Edge hold, active high (0 = edge acts) |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_step | input | 1 | 0 = load address, 1 = continue |
| wr_req_n | input | 1 | Burst direction at load: 0 write, 1 read |
| lane_wr_n | input | 4 | Per-lane write strobes, active low |
| addr | input | 8 | External word address |
| wdata | input | 32 | Write data, taken two enabled edges after its address |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 32 | Read data, zero when not driven |
| rdata_en | output | 1 | Read data valid and driven |

## Verification
The hardest case to reach is a clock hold that lands while accesses sit in both pipeline stages. The frozen state is then invisible at the ports unless the stream resumes exactly where it stopped. The stimulus holds for several cycles in the middle of read and write bursts. During the hold it drives deliberately conflicting selects, addresses and write data, then checks that both the output and the later readback match a sequence in which the held edges are skipped. Continue-deselect is reached the same way: every non-selecting pin combination is followed by a step cycle that carries live write strobes, and the target word is then read back.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  // Number of address bits the burst counter cycles through.
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/burst_sram_ctrl.sv
// Command decode and burst address sequencing; its registers form stage 1.
module burst_sram_ctrl
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_en,
  input  logic              chip_sel,
  input  logic              burst_step,
  input  logic              wr_req_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic              s1_active
);

  logic              dir_wr_q;
  op_e               op_d;
  logic [ADDR_W-1:0] addr_d;
  logic              act_d;
  logic              dir_d;
  logic [BURST_W-1:0] lo_inc;

  assign lo_inc = s1_addr[BURST_W-1:0] + BURST_W'(1);

  always_comb begin
    op_d   = OP_NONE;
    addr_d = s1_addr;
    act_d  = s1_active;
    dir_d  = dir_wr_q;
    if (!burst_step) begin
      if (chip_sel) begin
        act_d  = 1'b1;
        dir_d  = !wr_req_n;
        addr_d = addr;
        op_d   = (!wr_req_n) ? OP_WRITE : OP_READ;
      end else begin
        act_d = 1'b0;
      end
    end else if (s1_active) begin
      addr_d = {s1_addr[ADDR_W-1:BURST_W], lo_inc};
      op_d   = dir_wr_q ? OP_WRITE : OP_READ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op     <= OP_NONE;
      s1_addr   <= '0;
      s1_active <= 1'b0;
      dir_wr_q  <= 1'b0;
    end else if (edge_en) begin
      s1_op     <= op_d;
      s1_addr   <= addr_d;
      s1_active <= act_d;
      dir_wr_q  <= dir_d;
    end
  end

endmodule

// File: rtl/burst_sram_pipe.sv
// Carries the lane mask with stage 1 and moves the access into stage 2.
module burst_sram_pipe
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              edge_en,
  input  logic [LANES-1:0]  lane_wr_n,
  input  op_e               s1_op,
  input  logic [ADDR_W-1:0] s1_addr,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [LANES-1:0]  s2_mask_n
);

  logic [LANES-1:0] s1_mask_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_mask_n <= '1;
      s2_op     <= OP_NONE;
      s2_addr   <= '0;
      s2_mask_n <= '1;
    end else if (edge_en) begin
      s1_mask_n <= lane_wr_n;
      s2_op     <= s1_op;
      s2_addr   <= s1_addr;
      s2_mask_n <= s1_mask_n;
    end
  end

endmodule

// File: rtl/burst_sram_array.sv
// Lane-sliced storage with the output data register.
module burst_sram_array
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    edge_en,
  input  op_e                     s2_op,
  input  logic [ADDR_W-1:0]       s2_addr,
  input  logic [LANES-1:0]        s2_mask_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_vld
);

  localparam int DEPTH = 1 << ADDR_W;

  logic rd_go;
  logic wr_go;

  assign rd_go = edge_en && (s2_op == OP_READ);
  assign wr_go = edge_en && (s2_op == OP_WRITE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_go && !s2_mask_n[g]) begin
        mem[s2_addr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    always_ff @(posedge clk) begin
      if (rd_go) begin
        dout[g*LANE_W +: LANE_W] <= mem[s2_addr];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_vld <= 1'b0;
    end else if (edge_en) begin
      dout_vld <= (s2_op == OP_READ);
    end
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              burst_step,
  input  logic              wr_req_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_en
);

  logic              edge_en;
  logic              chip_sel;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic              s1_active;
  op_e               s2_op;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_mask_n;
  logic [DATA_W-1:0] dout;
  logic              dout_vld;

  assign edge_en  = !clk_en_n;
  assign chip_sel = !sel_a_n && sel_b && !sel_c_n;

  burst_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_en    (edge_en),
    .chip_sel   (chip_sel),
    .burst_step (burst_step),
    .wr_req_n   (wr_req_n),
    .addr       (addr),
    .s1_op      (s1_op),
    .s1_addr    (s1_addr),
    .s1_active  (s1_active)
  );

  burst_sram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_en   (edge_en),
    .lane_wr_n (lane_wr_n),
    .s1_op     (s1_op),
    .s1_addr   (s1_addr),
    .s2_op     (s2_op),
    .s2_addr   (s2_addr),
    .s2_mask_n (s2_mask_n)
  );

  burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_en   (edge_en),
    .s2_op     (s2_op),
    .s2_addr   (s2_addr),
    .s2_mask_n (s2_mask_n),
    .wdata     (wdata),
    .dout      (dout),
    .dout_vld  (dout_vld)
  );

  // Output drivers: the flag follows the enable pin without a clock.
  assign rdata_en = dout_vld && !out_en_n;
  assign rdata    = rdata_en ? dout : '0;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              burst_step,
  input logic [ADDR_W-1:0] addr,
  input logic              out_en_n,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_en,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              s1_active,
  input logic              dout_vld
);

  logic pin_sel;
  assign pin_sel = !sel_a_n && sel_b && !sel_c_n;

  // R10: a high enable pin always keeps the bus undriven.
  a_r10_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !rdata_en);

  // R10 / R1: undriven bus reads as zero.
  a_r10_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_en |-> (rdata == '0));

  // R2: a held edge changes neither the burst address nor the output state.
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(s1_addr) && $stable(s1_active) && $stable(dout_vld)));

  // R3: a non-selecting load edge ends the burst.
  a_r3_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !burst_step && !pin_sel) |=> !s1_active);

  // R4: a selecting load edge takes the external address.
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !burst_step && pin_sel) |=> (s1_active && s1_addr == $past(addr)));

  // R5: a continue edge wraps the two low bits and keeps the rest.
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && burst_step && s1_active) |=>
      (s1_active && s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2]) &&
       s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1));

  // R6: continuing while deselected stays deselected.
  a_r6_cont_desel: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && burst_step && !s1_active) |=> !s1_active);

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_en_n   (clk_en_n),
  .sel_a_n    (sel_a_n),
  .sel_b      (sel_b),
  .sel_c_n    (sel_c_n),
  .burst_step (burst_step),
  .addr       (addr),
  .out_en_n   (out_en_n),
  .rdata      (rdata),
  .rdata_en   (rdata_en),
  .s1_addr    (s1_addr),
  .s1_active  (s1_active),
  .dout_vld   (dout_vld)
);

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb;

  logic        clk;
  logic        rst_n;
  logic        clk_en_n;
  logic        sel_a_n, sel_b, sel_c_n;
  logic        burst_step;
  logic        wr_req_n;
  logic [3:0]  lane_wr_n;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic        out_en_n;
  logic [31:0] rdata;
  logic        rdata_en;

  int vecs = 0;
  int miss = 0;

  burst_sram u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .burst_step(burst_step), .wr_req_n(wr_req_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .wdata(wdata), .out_en_n(out_en_n),
    .rdata(rdata), .rdata_en(rdata_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Bench-side view of the requirements.
  typedef struct packed {
    logic [1:0]  kind;  // 0 none, 1 read, 2 write
    logic [7:0]  a;
    logic [3:0]  mk;
    logic [31:0] d;
  } bop_t;

  logic [31:0] mm [256];
  logic        m_act;
  logic        m_wr;
  logic [7:0]  m_cur;
  bop_t        p1, p2;
  logic        exp_vld;
  logic [31:0] exp_dat;

  function automatic logic [31:0] pat(input logic [7:0] a, input logic [7:0] s);
    return {a, ~a, a ^ s, a + s};
  endfunction

  task automatic check(input string tag);
    logic        e_en;
    logic [31:0] e_d;
    e_en = exp_vld && !out_en_n;
    e_d  = e_en ? exp_dat : 32'h0;
    vecs++;
    if (rdata_en !== e_en || rdata !== e_d) begin
      miss++;
      $display("FAIL %s: en=%0b data=%h expected en=%0b data=%h",
               tag, rdata_en, rdata, e_en, e_d);
    end
  endtask

  // One clock: drive at the falling edge, model at the rising edge, check after.
  task automatic cyc(input logic [2:0] selc, input logic stp, input logic wrn,
                     input logic [3:0] lanes, input logic [7:0] ad,
                     input logic [31:0] d, input logic oe, input logic hold,
                     input string tag);
    bop_t nw;
    logic sel;
    {sel_a_n, sel_b, sel_c_n} = selc;
    burst_step = stp;
    wr_req_n   = wrn;
    lane_wr_n  = lanes;
    addr       = ad;
    out_en_n   = oe;
    clk_en_n   = hold;
    wdata      = (p2.kind == 2'd2) ? p2.d : ~d;
    @(posedge clk);
    if (!hold) begin
      if (p2.kind == 2'd2) begin
        for (int l = 0; l < 4; l++)
          if (!p2.mk[l]) mm[p2.a][l*8 +: 8] = p2.d[l*8 +: 8];
        exp_vld = 1'b0;
      end else if (p2.kind == 2'd1) begin
        exp_vld = 1'b1;
        exp_dat = mm[p2.a];
      end else begin
        exp_vld = 1'b0;
      end
      p2  = p1;
      nw  = '0;
      sel = (selc == 3'b010);
      if (!stp) begin
        if (sel) begin
          m_act = 1'b1; m_wr = !wrn; m_cur = ad;
          nw.kind = m_wr ? 2'd2 : 2'd1;
        end else begin
          m_act = 1'b0;
        end
      end else if (m_act) begin
        m_cur = {m_cur[7:2], m_cur[1:0] + 2'd1};
        nw.kind = m_wr ? 2'd2 : 2'd1;
      end
      nw.a = m_cur; nw.mk = lanes; nw.d = d;
      p1 = nw;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++)
      cyc(3'b100, 1'b0, 1'b1, 4'hF, 8'h00, 32'h0, 1'b0, 1'b0, tag);
  endtask

  function automatic logic [7:0] baddr(input logic [7:0] st, input int i);
    return {st[7:2], st[1:0] + 2'(i)};
  endfunction

  initial begin
    #2_000_000;
    miss++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    logic [7:0] st;
    m_act = 1'b0; m_wr = 1'b0; m_cur = '0;
    p1 = '0; p2 = '0; exp_vld = 1'b0; exp_dat = '0;
    for (int i = 0; i < 256; i++) mm[i] = 32'h0;
    rst_n = 1'b0; clk_en_n = 1'b0;
    {sel_a_n, sel_b, sel_c_n} = 3'b100;
    burst_step = 1'b0; wr_req_n = 1'b1; lane_wr_n = 4'hF;
    addr = '0; wdata = '0; out_en_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    idle(3, "R1 after reset");

    // Fill the whole array with write bursts at rotating start offsets (R4, R5, R9).
    for (int b = 0; b < 64; b++) begin
      st = 8'(b * 4 + (b % 4));
      cyc(3'b010, 1'b0, 1'b0, 4'h0, st, pat(st, 8'h11), 1'b0, 1'b0, "R4 write load");
      for (int i = 1; i < 4; i++)
        cyc(3'b010, 1'b1, 1'b1, 4'h0, 8'h00, pat(baddr(st, i), 8'h11), 1'b0, 1'b0,
            "R5 write step");
    end
    idle(2, "R9 flush");

    // Read everything back with a different start offset per burst (R5, R9).
    for (int b = 0; b < 64; b++) begin
      st = 8'(b * 4 + ((b + 1) % 4));
      cyc(3'b010, 1'b0, 1'b1, 4'h0, st, 32'h0, 1'b0, 1'b0, "R4 read load");
      for (int i = 1; i < 4; i++)
        cyc(3'b010, 1'b1, 1'b0, 4'h0, 8'h00, 32'h0, 1'b0, 1'b0, "R5 read wrap");
    end
    idle(2, "R9 flush");

    // Every lane mask, including the abort mask (R7, R8).
    for (int m = 0; m < 16; m++) begin
      st = 8'h40 + 8'(m);
      cyc(3'b010, 1'b0, 1'b0, 4'(m), st, pat(st, 8'h77), 1'b0, 1'b0, "R7 masked write");
      cyc(3'b010, 1'b0, 1'b1, 4'h0, st, 32'h0, 1'b0, 1'b0, "R7 readback");
      cyc(3'b010, 1'b0, 1'b1, 4'h0, st, 32'h0, 1'b0, 1'b0, "R8 readback");
    end
    // Abort inside a burst: the address still advances (R8).
    cyc(3'b010, 1'b0, 1'b0, 4'hF, 8'h50, 32'hFFFF_FFFF, 1'b0, 1'b0, "R8 abort load");
    cyc(3'b010, 1'b1, 1'b0, 4'h0, 8'h00, 32'hA5A5_5A5A, 1'b0, 1'b0, "R8 step write");
    cyc(3'b010, 1'b0, 1'b1, 4'h0, 8'h50, 32'h0, 1'b0, 1'b0, "R8 read aborted");
    cyc(3'b010, 1'b0, 1'b1, 4'h0, 8'h51, 32'h0, 1'b0, 1'b0, "R8 read stepped");
    idle(2, "R8 flush");

    // Every non-selecting pin combination, then continue-deselect with live strobes (R3, R6).
    for (int c = 0; c < 8; c++) begin
      if (c == 2) continue;
      cyc(3'(c), 1'b0, 1'b0, 4'h0, 8'h80, 32'hFFFF_FFFF, 1'b0, 1'b0, "R3 deselect");
      cyc(3'b010, 1'b1, 1'b0, 4'h0, 8'h81, 32'hFFFF_FFFF, 1'b0, 1'b0, "R6 cont deselect");
      cyc(3'b010, 1'b1, 1'b0, 4'h0, 8'h82, 32'hFFFF_FFFF, 1'b0, 1'b0, "R6 cont deselect");
      cyc(3'b010, 1'b0, 1'b1, 4'h0, 8'h80, 32'h0, 1'b0, 1'b0, "R3 read");
      cyc(3'b010, 1'b1, 1'b1, 4'h0, 8'h00, 32'h0, 1'b0, 1'b0, "R6 read");
      cyc(3'b010, 1'b1, 1'b1, 4'h0, 8'h00, 32'h0, 1'b0, 1'b0, "R6 read");
      idle(2, "R6 flush");
    end

    // Hold edges in the middle of read and write bursts (R2).
    cyc(3'b010, 1'b0, 1'b1, 4'h0, 8'h22, 32'h0, 1'b0, 1'b0, "R2 read load");
    cyc(3'b010, 1'b1, 1'b1, 4'h0, 8'h00, 32'h0, 1'b0, 1'b0, "R2 read step");
    for (int h = 0; h < 4; h++)
      cyc(3'(h), 1'(h), 1'b0, 4'h0, 8'hEE, 32'hDEAD_0000, 1'b0, 1'b1, "R2 hold");
    for (int i = 0; i < 2; i++)
      cyc(3'b010, 1'b1, 1'b1, 4'h0, 8'h00, 32'h0, 1'b0, 1'b0, "R2 resume");
    cyc(3'b010, 1'b0, 1'b0, 4'h3, 8'h90, 32'h1357_9BDF, 1'b0, 1'b0, "R2 write load");
    cyc(3'b010, 1'b1, 1'b0, 4'hC, 8'h00, 32'h2468_ACE0, 1'b0, 1'b0, "R2 write step");
    for (int h = 0; h < 3; h++)
      cyc(3'b010, 1'b0, 1'b0, 4'h0, 8'h91, 32'hFFFF_FFFF, 1'b0, 1'b1, "R2 hold");
    idle(2, "R2 drain");
    cyc(3'b010, 1'b0, 1'b1, 4'h0, 8'h90, 32'h0, 1'b0, 1'b0, "R2 readback");
    cyc(3'b010, 1'b1, 1'b1, 4'h0, 8'h00, 32'h0, 1'b0, 1'b0, "R2 readback");
    idle(2, "R2 flush");

    // Output enable high: dummy reads still step the address (R10).
    cyc(3'b010, 1'b0, 1'b1, 4'h0, 8'h30, 32'h0, 1'b0, 1'b0, "R10 load");
    for (int i = 1; i < 8; i++)
      cyc(3'b010, 1'b1, 1'b1, 4'h0, 8'h00, 32'h0, 1'(i % 3 == 0), 1'b0, "R10 oe gate");
    idle(2, "R10 flush");

    // Alternating writes and reads with no gap (R11).
    for (int i = 0; i < 32; i++) begin
      st = 8'hA0 + 8'(i);
      cyc(3'b010, 1'b0, 1'b0, 4'h0, st, pat(st, 8'h33), 1'b0, 1'b0, "R11 write");
      cyc(3'b010, 1'b0, 1'b1, 4'h0, st, 32'h0, 1'b0, 1'b0, "R11 read");
    end
    idle(3, "R11 flush");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule